// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block tracks in-flight instructions for an out-of-order core and retires them in program order. At dispatch, an instruction presents its micro-op count and a tag. The controller turns the count into a slot count: zero becomes one, and anything above the buffer size becomes the buffer size. It reserves that many contiguous slots in a circular buffer and hands back the index of the first slot. That index is the instruction's token.

When the execution units report that an instruction has passed write-back, they quote its token and the controller sets that entry's executed flag. In every cycle the controller walks forward from the oldest entry. It retires executed entries one after another and stops at the first entry that has not executed or at the per-cycle limit. For every retired entry it raises a retire lane carrying the tag and gives the entry's slots back to the free pool.

The dispatch side sees an acceptance flag for the request it presents, and an empty flag shows when nothing is in flight. The per-cycle limit is a parameter, and the value zero removes the limit.

Top module: `rob_retire_ctrl`

## Requirements
- R1: The slot need of a request is its micro-op count, with 0 raised to 1 and any count above DEPTH lowered to DEPTH. `disp_ready` is 1 exactly when the free slot count is at least that need.
- R2: An accepted dispatch (`disp_valid` and `disp_ready` high at a clock edge) returns `disp_token` equal to the write position before the edge. The write position then moves forward by the slot need, modulo DEPTH.
- R3: Retirement follows program order. An executed entry never retires while an older entry is still in flight, and retire lane k is active only if lane k-1 is active.
- R4: At most RETIRE_MAX entries retire in one cycle. With RETIRE_MAX = 0, every executed entry in an unbroken run from the oldest entry retires in the same cycle.
- R5: The slots of an entry return to the free pool only at the edge that ends its retire cycle. A dispatch in that same cycle is judged against the free count before those slots are returned.
- R6: `empty` is 1 exactly when the free slot count equals DEPTH. While `empty` is 1, no retire lane is active.
- R7: A dispatch that is not accepted, or no dispatch at all, leaves the write position unchanged (`disp_token` stable) and reserves no slots.
- R8: `exe_valid` with `exe_token` marks that entry as executed. Retire lane k drives that entry's tag on `ret_tag[k*TAG_W +: TAG_W]`. Retirement is combinational: the lane becomes active in the cycle after the marking edge.
- R9: After reset the buffer is empty, `disp_token` is 0 and no retire lane is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_uops | input | UOP_W | Micro-op count of the request |
| disp_tag | input | TAG_W | Instruction tag stored with the entry |
| disp_ready | output | 1 | Enough free slots for the presented request |
| disp_token | output | IDX_W | Token index an accepted request receives |
| exe_valid | input | 1 | Execution-complete event |
| exe_token | input | IDX_W | Token of the completed instruction |
| ret_valid | output | LANES | Retire lane active flags, lane 0 oldest |
| ret_tag | output | LANES*TAG_W | Tags of the retiring instructions, per lane |
| empty | output | 1 | No instruction in flight |

## Verification
Two things can happen in the same cycle. An instruction can retire while a new request is being dispatched, and an executed event can arrive for an entry that is waiting behind an older one. The bench provokes the first case in a directed step. It fills the whole buffer with one clamped request, then presents a one-slot request in the very cycle that entry retires, and expects a rejection there and an acceptance one cycle later. Long random runs mix dispatches, out-of-order executed events and retirements in the same cycles. A reference queue model in the bench judges acceptance, tokens, lane tags and the empty flag on every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Number of retire lanes: zero or an oversize limit means one lane per slot.
   function automatic int lane_count(input int limit, input int depth);
      return (limit == 0 || limit > depth) ? depth : limit;
   endfunction

   function automatic int idx_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

   // Circular add of an offset (at most depth) to a position below depth.
   function automatic int wrap_add(input int pos, input int step, input int depth);
      int s;
      s = pos + step;
      return (s >= depth) ? s - depth : s;
   endfunction

endpackage

// File: rtl/rob_slot_norm.sv
module rob_slot_norm #(
   parameter int DEPTH = 16,
   parameter int UOP_W = 5,
   parameter int CNT_W = 5
) (
   input  logic [UOP_W-1:0] uops,
   output logic [CNT_W-1:0] nslots
);

   localparam int UOP_MAX = (1 << UOP_W) - 1;

   generate
      if (UOP_MAX > DEPTH) begin : g_clamp
         always_comb begin
            if (uops == '0)
               nslots = CNT_W'(1);
            else if (int'(uops) > DEPTH)
               nslots = CNT_W'(DEPTH);
            else
               nslots = CNT_W'(uops);
         end
      end else begin : g_noclamp
         always_comb begin
            if (uops == '0)
               nslots = CNT_W'(1);
            else
               nslots = CNT_W'(uops);
         end
      end
   endgenerate

endmodule

// File: rtl/rob_token_store.sv
module rob_token_store #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 8,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [CNT_W-1:0] wr_n,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx,
   output logic [TAG_W-1:0] tag_o [DEPTH],
   output logic [CNT_W-1:0] n_o   [DEPTH],
   output logic             ex_o  [DEPTH]
);

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic hit_wr, hit_mark;
         assign hit_wr   = wr_en   && (int'(wr_idx)   == s);
         assign hit_mark = mark_en && (int'(mark_idx) == s);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_o[s] <= '0;
               n_o[s]   <= CNT_W'(1);
               ex_o[s]  <= 1'b0;
            end else begin
               if (hit_wr) begin
                  tag_o[s] <= wr_tag;
                  n_o[s]   <= wr_n;
                  ex_o[s]  <= 1'b0;
               end else if (hit_mark) begin
                  ex_o[s]  <= 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rob_retire_select.sv
module rob_retire_select #(
   parameter int DEPTH = 16,
   parameter int LANES = 2,
   parameter int TAG_W = 8,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0]       head,
   input  logic [CNT_W-1:0]       occupied,
   input  logic [TAG_W-1:0]       tags [DEPTH],
   input  logic [CNT_W-1:0]       ns   [DEPTH],
   input  logic                   ex   [DEPTH],
   output logic [LANES-1:0]       ret_valid,
   output logic [LANES*TAG_W-1:0] ret_tag,
   output logic [CNT_W-1:0]       freed,
   output logic [IDX_W-1:0]       head_next
);

   logic [IDX_W-1:0] ptr [LANES+1];
   logic [CNT_W-1:0] cum [LANES+1];
   logic             go  [LANES+1];

   assign ptr[0] = head;
   assign cum[0] = '0;
   assign go[0]  = 1'b1;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [CNT_W-1:0] n_here;
         logic             ok;
         assign n_here = ns[ptr[k]];
         assign ok     = go[k] && (cum[k] < occupied) && ex[ptr[k]];
         assign ret_valid[k]              = ok;
         assign ret_tag[k*TAG_W +: TAG_W] = tags[ptr[k]];
         assign go[k+1]  = ok;
         assign cum[k+1] = ok ? cum[k] + n_here : cum[k];
         assign ptr[k+1] = IDX_W'(rob_pkg::wrap_add(int'(ptr[k]), int'(n_here), DEPTH));
      end
   endgenerate

   assign freed     = cum[LANES];
   assign head_next = IDX_W'(rob_pkg::wrap_add(int'(head), int'(cum[LANES]), DEPTH));

endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl #(
   parameter int DEPTH      = 16,
   parameter int TAG_W      = 8,
   parameter int UOP_W      = 5,
   parameter int RETIRE_MAX = 2,
   localparam int IDX_W     = rob_pkg::idx_width(DEPTH),
   localparam int LANES     = rob_pkg::lane_count(RETIRE_MAX, DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   disp_valid,
   input  logic [UOP_W-1:0]       disp_uops,
   input  logic [TAG_W-1:0]       disp_tag,
   output logic                   disp_ready,
   output logic [IDX_W-1:0]       disp_token,
   input  logic                   exe_valid,
   input  logic [IDX_W-1:0]       exe_token,
   output logic [LANES-1:0]       ret_valid,
   output logic [LANES*TAG_W-1:0] ret_tag,
   output logic                   empty
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rob_retire_ctrl: DEPTH must be at least 2");
      end
      if (TAG_W < 1 || UOP_W < 1) begin : g_bad_width
         $error("rob_retire_ctrl: TAG_W and UOP_W must be positive");
      end
      if (RETIRE_MAX < 0) begin : g_bad_limit
         $error("rob_retire_ctrl: RETIRE_MAX must not be negative");
      end
   endgenerate

   logic [CNT_W-1:0] free_q;
   logic [IDX_W-1:0] head_q, tail_q, head_nx;
   logic [CNT_W-1:0] need, freed, occupied;
   logic             fire;

   logic [TAG_W-1:0] st_tag [DEPTH];
   logic [CNT_W-1:0] st_n   [DEPTH];
   logic             st_ex  [DEPTH];

   rob_slot_norm #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_norm (
      .uops   (disp_uops),
      .nslots (need)
   );

   rob_token_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fire),
      .wr_idx   (tail_q),
      .wr_tag   (disp_tag),
      .wr_n     (need),
      .mark_en  (exe_valid),
      .mark_idx (exe_token),
      .tag_o    (st_tag),
      .n_o      (st_n),
      .ex_o     (st_ex)
   );

   assign occupied = CNT_W'(DEPTH) - free_q;

   rob_retire_select #(.DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W),
                       .CNT_W(CNT_W), .IDX_W(IDX_W)) u_select (
      .head      (head_q),
      .occupied  (occupied),
      .tags      (st_tag),
      .ns        (st_n),
      .ex        (st_ex),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .freed     (freed),
      .head_next (head_nx)
   );

   // Acceptance uses the free count before this cycle's retirements.
   assign disp_ready = (free_q >= need);
   assign fire       = disp_valid && disp_ready;
   assign disp_token = tail_q;
   assign empty      = (free_q == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= CNT_W'(DEPTH);
         head_q <= '0;
         tail_q <= '0;
      end else begin
         free_q <= free_q + freed - (fire ? need : CNT_W'(0));
         head_q <= head_nx;
         if (fire)
            tail_q <= IDX_W'(rob_pkg::wrap_add(int'(tail_q), int'(need), DEPTH));
      end
   end

endmodule

// File: rtl/rob_retire_ctrl_chk.sv
module rob_retire_ctrl_chk #(
   parameter int DEPTH = 16,
   parameter int UOP_W = 5,
   parameter int IDX_W = 4,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_valid,
   input logic [UOP_W-1:0] disp_uops,
   input logic             disp_ready,
   input logic [IDX_W-1:0] disp_token,
   input logic [LANES-1:0] ret_valid,
   input logic             empty
);

   function automatic int need_of(input logic [UOP_W-1:0] u);
      if (u == '0) return 1;
      if (int'(u) > DEPTH) return DEPTH;
      return int'(u);
   endfunction

   generate
      for (genvar k = 1; k < LANES; k++) begin : g_ord
         // R3
         lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[k] |-> ret_valid[k-1]);
      end
   endgenerate

   // R6
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (ret_valid == '0));

   // R1
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> disp_ready);

   // R2
   token_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |=>
      (int'(disp_token) == rob_pkg::wrap_add(int'($past(disp_token)),
                                             need_of($past(disp_uops)), DEPTH)));

   // R7
   token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(disp_valid && disp_ready) |=> $stable(disp_token));

endmodule

bind rob_retire_ctrl rob_retire_ctrl_chk #(
   .DEPTH(DEPTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .LANES(LANES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .disp_uops  (disp_uops),
   .disp_ready (disp_ready),
   .disp_token (disp_token),
   .ret_valid  (ret_valid),
   .empty      (empty)
);

// File: tb/rob_retire_ctrl_test.sv
`timescale 1ns/1ps
module rob_retire_ctrl_test;

   localparam int DEPTH = 16;
   localparam int TAG_W = 8;
   localparam int UOP_W = 5;
   localparam int LIM   = 2;
   localparam int IDX_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             disp_valid = 1'b0;
   logic [UOP_W-1:0] disp_uops = '0;
   logic [TAG_W-1:0] disp_tag = '0;
   logic             disp_ready;
   logic [IDX_W-1:0] disp_token;
   logic             exe_valid = 1'b0;
   logic [IDX_W-1:0] exe_token = '0;
   logic [LIM-1:0]   ret_valid;
   logic [LIM*TAG_W-1:0] ret_tag;
   logic             empty;

   rob_retire_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W), .RETIRE_MAX(LIM)) uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_uops(disp_uops), .disp_tag(disp_tag),
      .disp_ready(disp_ready), .disp_token(disp_token),
      .exe_valid(exe_valid), .exe_token(exe_token),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .empty(empty)
   );

   // Second instance with no retire limit.
   logic             d2_valid = 1'b0;
   logic [UOP_W-1:0] d2_uops = '0;
   logic [TAG_W-1:0] d2_tag = '0;
   logic             d2_ready;
   logic [IDX_W-1:0] d2_token;
   logic             e2_valid = 1'b0;
   logic [IDX_W-1:0] e2_token = '0;
   logic [DEPTH-1:0] r2_valid;
   logic [DEPTH*TAG_W-1:0] r2_tag;
   logic             e2_empty;

   rob_retire_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W), .RETIRE_MAX(0)) uut_nolim (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(d2_valid), .disp_uops(d2_uops), .disp_tag(d2_tag),
      .disp_ready(d2_ready), .disp_token(d2_token),
      .exe_valid(e2_valid), .exe_token(e2_token),
      .ret_valid(r2_valid), .ret_tag(r2_tag), .empty(e2_empty)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Reference queue model
   int m_head = 0, m_tail = 0, m_free = DEPTH;
   int m_tag [DEPTH];
   int m_n   [DEPTH];
   bit m_ex  [DEPTH];

   function automatic int need_of(input int u);
      if (u == 0) return 1;
      if (u > DEPTH) return DEPTH;
      return u;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pick_inflight(output bit found, output int idx);
      int p, used, cnt, r;
      p = m_head; used = 0; cnt = 0;
      while (used < DEPTH - m_free) begin
         used += m_n[p]; p = (p + m_n[p]) % DEPTH; cnt++;
      end
      found = (cnt > 0);
      idx = m_head;
      if (found) begin
         r = int'($urandom % cnt);
         p = m_head;
         for (int i = 0; i < r; i++) p = (p + m_n[p]) % DEPTH;
         idx = p;
      end
   endtask

   // Drive inputs at negedge, check outputs, advance model, cross one edge.
   task automatic step(input bit dv, input int du, input int dt, input bit ev, input int et);
      int p, used, cnt, need;
      int exp_tag [LIM];
      bit rdy;
      disp_valid = dv; disp_uops = UOP_W'(du); disp_tag = TAG_W'(dt);
      exe_valid = ev; exe_token = IDX_W'(et);
      #1;
      need = need_of(du);
      rdy = (m_free >= need);
      p = m_head; used = 0; cnt = 0;
      while (cnt < LIM && used < DEPTH - m_free && m_ex[p]) begin
         exp_tag[cnt] = m_tag[p]; used += m_n[p]; p = (p + m_n[p]) % DEPTH; cnt++;
      end
      chk(disp_ready == rdy, "R1 R5 ready", int'(disp_ready), int'(rdy));
      chk(int'(disp_token) == m_tail, "R2 token", int'(disp_token), m_tail);
      chk(empty == (m_free == DEPTH), "R6 empty", int'(empty), int'(m_free == DEPTH));
      for (int k = 0; k < LIM; k++) begin
         chk(ret_valid[k] == (k < cnt), "R3 R4 lane", int'(ret_valid[k]), int'(k < cnt));
         if (k < cnt)
            chk(int'(ret_tag[k*TAG_W +: TAG_W]) == exp_tag[k], "R8 tag",
                int'(ret_tag[k*TAG_W +: TAG_W]), exp_tag[k]);
      end
      m_free += used; m_head = p;
      if (ev) m_ex[et] = 1'b1;
      if (dv && rdy) begin
         m_tag[m_tail] = dt & 8'hFF; m_n[m_tail] = need; m_ex[m_tail] = 1'b0;
         m_tail = (m_tail + need) % DEPTH; m_free -= need;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      int tmp_idx;
      bit tmp_found;
      void'($urandom(32'h5eed_0b1e));
      for (int i = 0; i < DEPTH; i++) begin m_tag[i] = 0; m_n[i] = 1; m_ex[i] = 0; end
      repeat (2) @(negedge clk);
      // R9 reset state
      chk(empty == 1'b1, "R9 empty", int'(empty), 1);
      chk(ret_valid == '0, "R9 ret", int'(ret_valid), 0);
      chk(disp_token == '0, "R9 token", int'(disp_token), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 zero micro-ops needs one slot
      step(1, 0, 8'h11, 0, 0);
      chk(int'(disp_token) == 1, "R1 R2 zero-uop advance", int'(disp_token), 1);
      // R7 oversized request rejected while one slot used
      step(1, 31, 8'h99, 0, 0);
      chk(int'(disp_token) == 1, "R7 reject keeps token", int'(disp_token), 1);
      chk(disp_ready == 1'b0, "R7 still full-size short", int'(disp_ready), 0);
      // R3 younger executes first and must wait
      step(1, 3, 8'h22, 0, 0);
      step(0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 0);
      chk(ret_valid == '0, "R3 younger waits", int'(ret_valid), 0);
      step(0, 0, 0, 1, 0);
      chk(ret_valid == 2'b11, "R3 R4 both retire", int'(ret_valid), 3);
      step(0, 0, 0, 0, 0);
      chk(empty == 1'b1, "R6 drained", int'(empty), 1);
      // R1 clamp: a 31-uop request takes the whole buffer
      step(1, 31, 8'h33, 0, 0);
      chk(empty == 1'b0 && disp_ready == 1'b0, "R1 clamp fills", int'(disp_ready), 0);
      step(0, 0, 0, 1, 4);
      // R5 retiring cycle: the freed slots are not yet usable
      disp_uops = UOP_W'(1); #1;
      chk(ret_valid[0] == 1'b1, "R8 retire after exe", int'(ret_valid[0]), 1);
      chk(disp_ready == 1'b0, "R5 no reuse same cycle", int'(disp_ready), 0);
      step(1, 1, 8'h44, 0, 0);
      chk(disp_ready == 1'b1 && empty == 1'b1, "R5 freed next cycle", int'(disp_ready), 1);

      // Constrained random traffic
      for (int c = 0; c < 4000; c++) begin
         int du;
         bit ev;
         du = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 5);
         pick_inflight(tmp_found, tmp_idx);
         ev = tmp_found && ($urandom % 2 == 0);
         step($urandom % 3 != 0, du, int'($urandom % 256), ev, tmp_idx);
      end

      // R4 unlimited instance: five executed entries retire together
      for (int i = 0; i < 5; i++) begin
         d2_valid = 1'b1; d2_uops = UOP_W'(1); d2_tag = TAG_W'(8'h50 + i);
         @(posedge clk); @(negedge clk);
      end
      d2_valid = 1'b0;
      for (int i = 4; i >= 0; i--) begin
         e2_valid = 1'b1; e2_token = IDX_W'(i);
         @(posedge clk); @(negedge clk);
         if (i > 0) chk(r2_valid == '0, "R3 unlimited waits", int'(r2_valid), 0);
      end
      e2_valid = 1'b0; #1;
      chk($countones(r2_valid) == 5, "R4 unlimited count", $countones(r2_valid), 5);
      chk(int'(r2_tag[4*TAG_W +: TAG_W]) == 8'h54, "R8 lane4 tag",
          int'(r2_tag[4*TAG_W +: TAG_W]), 8'h54);
      @(posedge clk); @(negedge clk);
      chk(e2_empty == 1'b1, "R6 unlimited drained", int'(e2_empty), 1);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule